// File: doc/BRIEF.md
# Delayed-Write Pipelined SRAM

A synchronous single-port memory whose command interface runs at one transfer per clock. Every rising edge samples an active-low primary enable, two secondary enables whose polarity is fixed by two strap inputs, a load/continue strobe, a write enable and active-low byte enables. A read returns its data one cycle later through an output register. A write gives only its address and byte mask when it is issued, and its data follows on the second edge after the command. This lets read and write traffic share the bus back to back with no turnaround cycle.

A two-bit burst counter lets a host issue one base address and then up to three continue cycles. The continue cycles step through the aligned group of four words in linear order and then wrap back to the start. The block drives an output-enable flag with its data bus and a separate echo-clock enable. These two outputs respond differently to the two kinds of deselect. Read data is always coherent with writes that are still waiting for their data.

Top module: `dlw_sram`

## Requirements
- R1: When `load_n` is low and all three enables are true, a new access starts at `addr`. `we_n` high makes it a read and `we_n` low makes it a write.
- R2: A read sampled on edge n drives the word on `dout` with `dout_oe` high from edge n+1 until the next edge.
- R3: The data for a write sampled on edge n is taken from `din` on edge n+2.
- R4: `en2` is true only when it equals `pol2`, and `en3` is true only when it equals `pol3`. `en1_n` is true when low. If any enable is false, a load cycle starts no access.
- R5: `be_n[i]` low enables byte i, which is bits 9i+8..9i of the word. A write with every `be_n` bit high stores nothing, but its address is still loaded for the burst.
- R6: `load_n` high is a continue cycle. It repeats the previous operation type at the previous address with bits 1:0 incremented. During a continue, `we_n` and the enables are ignored, and `be_n` is sampled fresh for each write beat.
- R7: A fourth continue in a row returns to the loaded base address. Address bits above bit 1 never change during a burst.
- R8: A primary deselect (`en1_n` high while the secondary enables are true) or a write drives `dout_oe` low after the next edge, while `echo_en` stays high.
- R9: A bank deselect (a secondary enable false on a load cycle) drives both `dout_oe` and `echo_en` low after the next edge. A continue that follows a deselect stays deselected. Reset leaves the block in the bank-deselected state with both flags low.
- R10: A read of an address whose write data has not yet been stored returns the newest bytes: the pending data is merged into the stored word according to the write's byte mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| en1_n | input | 1 | Primary enable, active low |
| en2 | input | 1 | Secondary enable, true when equal to `pol2` |
| en3 | input | 1 | Secondary enable, true when equal to `pol3` |
| pol2 | input | 1 | Strap setting the true level of `en2` |
| pol3 | input | 1 | Strap setting the true level of `en3` |
| load_n | input | 1 | Low loads a new address, high continues the burst |
| we_n | input | 1 | Low selects write, high selects read |
| be_n | input | NB | Byte write enables, active low |
| addr | input | AW | Word address |
| din | input | NB*BW | Write data, sampled two edges after the command |
| dout | output | NB*BW | Read data |
| dout_oe | output | 1 | Data bus drive enable |
| echo_en | output | 1 | Echo clock drive enable |

## Verification
The memory is first filled with full-mask writes. Directed runs then check the following cases:
- A lone read, and a read issued right after a write to the same address, both with full and partial masks. This separates store-then-read behaviour from the in-flight merge.
- A write with all byte enables high. This shows that an abort still loads the burst address but leaves the data unchanged.
- Bursts of five beats with junk on the enables and `we_n` during the continue cycles. These show the linear wrap and that continues ignore those inputs.
- Both deselect kinds, each followed by a continue. These show which deselect silences the echo flag.

A long random command stream, with mixed straps and bank switches, is compared cycle by cycle against a behavioural reference model.

// File: rtl/dlw_sram.sv
module dlw_sram #(
  parameter int AW = 6,
  parameter int NB = 2,
  parameter int BW = 9
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               en1_n,
  input  logic               en2,
  input  logic               en3,
  input  logic               pol2,
  input  logic               pol3,
  input  logic               load_n,
  input  logic               we_n,
  input  logic [NB-1:0]      be_n,
  input  logic [AW-1:0]      addr,
  input  logic [NB*BW-1:0]   din,
  output logic [NB*BW-1:0]   dout,
  output logic               dout_oe,
  output logic               echo_en
);
  localparam int DW    = NB * BW;
  localparam int DEPTH = 1 << AW;

  typedef enum logic [1:0] {K_BANK, K_DESEL, K_RD, K_WR} kind_t;

  logic [DW-1:0] mem [DEPTH];

  kind_t         last_q, kind;
  logic [AW-1:0] cur_q, acc_addr;
  logic [1:0]    nxt_lo;
  logic          bank_ok;

  logic          s1_v, s2_v, rd_v, bank_q;
  logic [AW-1:0] s1_a, s2_a, rd_a;
  logic [NB-1:0] s1_m, s2_m;
  logic [DW-1:0] rd_word;

  assign bank_ok  = (en2 == pol2) && (en3 == pol3);
  assign nxt_lo   = cur_q[1:0] + 2'd1;
  assign acc_addr = load_n ? {cur_q[AW-1:2], nxt_lo} : addr;

  always_comb begin
    if (load_n)       kind = last_q;
    else if (!bank_ok) kind = K_BANK;
    else if (en1_n)   kind = K_DESEL;
    else if (we_n)    kind = K_RD;
    else              kind = K_WR;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      last_q <= K_BANK;
      cur_q  <= '0;
      s1_v   <= 1'b0;
      s2_v   <= 1'b0;
      rd_v   <= 1'b0;
      bank_q <= 1'b1;
    end else begin
      last_q <= kind;
      cur_q  <= acc_addr;
      s1_v   <= (kind == K_WR) && !(&be_n);
      s2_v   <= s1_v;
      rd_v   <= (kind == K_RD);
      bank_q <= (kind == K_BANK);
    end
    s1_a <= acc_addr;
    s1_m <= ~be_n;
    s2_a <= s1_a;
    s2_m <= s1_m;
    rd_a <= acc_addr;
  end

  always_ff @(posedge clk) begin
    for (int b = 0; b < NB; b++)
      if (!rst && s2_v && s2_m[b]) mem[s2_a][b*BW +: BW] <= din[b*BW +: BW];
  end

  always_comb begin
    rd_word = mem[rd_a];
    for (int b = 0; b < NB; b++)
      if (s2_v && s2_m[b] && (s2_a == rd_a)) rd_word[b*BW +: BW] = din[b*BW +: BW];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dout    <= '0;
      dout_oe <= 1'b0;
      echo_en <= 1'b0;
    end else begin
      if (rd_v) dout <= rd_word;
      dout_oe <= rd_v;
      echo_en <= !bank_q;
    end
  end

  assert_read_drives_R2: assert property (@(posedge clk) disable iff (rst)
    (kind == K_RD) |=> ##1 dout_oe);

  assert_write_tristate_R8: assert property (@(posedge clk) disable iff (rst)
    (kind == K_WR) |=> ##1 !dout_oe);

  assert_bank_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    (kind == K_BANK) |=> ##1 (!dout_oe && !echo_en));

  assert_burst_upper_R7: assert property (@(posedge clk) disable iff (rst)
    load_n |=> (cur_q[AW-1:2] == $past(cur_q[AW-1:2])));

  assert_oe_echo_R8: assert property (@(posedge clk) disable iff (rst)
    dout_oe |-> echo_en);
endmodule

// File: tb/dlw_sram_test.sv
module dlw_sram_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en1_n = 1'b1, en2 = 1'b0, en3 = 1'b0, pol2 = 1'b0, pol3 = 1'b0;
  logic load_n = 1'b0, we_n = 1'b1;
  logic [1:0]  be_n = 2'b11;
  logic [5:0]  addr = '0;
  logic [17:0] din = '0;
  logic [17:0] dout;
  logic        dout_oe, echo_en;

  always #2 clk = ~clk;

  dlw_sram uut (.clk(clk), .rst(rst), .en1_n(en1_n), .en2(en2), .en3(en3),
    .pol2(pol2), .pol3(pol3), .load_n(load_n), .we_n(we_n), .be_n(be_n),
    .addr(addr), .din(din), .dout(dout), .dout_oe(dout_oe), .echo_en(echo_en));

  int ncmp = 0, nbad = 0, cyc = 0;
  string req_tag = "R9";

  logic [17:0] refm [64];
  int          pq_due[$];
  logic [5:0]  pq_addr[$];
  logic [1:0]  pq_m[$];
  int          pk = 0, lk = 0;
  logic [5:0]  ca = '0, prd_a = '0;

  task automatic check(input string what, input logic [17:0] got, input logic [17:0] exp);
    ncmp++;
    if (got !== exp) begin
      nbad++;
      $display("FAIL %s %s at cycle %0d: got %h expected %h", req_tag, what, cyc, got, exp);
    end
  endtask

  task automatic model_edge();
    int k;
    cyc++;
    while (pq_due.size() > 0 && pq_due[0] == cyc) begin
      if (pq_m[0][0]) refm[pq_addr[0]][8:0]  = din[8:0];
      if (pq_m[0][1]) refm[pq_addr[0]][17:9] = din[17:9];
      void'(pq_due.pop_front()); void'(pq_addr.pop_front()); void'(pq_m.pop_front());
    end
    check("dout_oe", {17'b0, dout_oe}, {17'b0, pk == 2});
    check("echo_en", {17'b0, echo_en}, {17'b0, pk != 0});
    if (pk == 2) check("dout", dout, refm[prd_a]);
    if (!load_n) begin
      if (!(en2 == pol2 && en3 == pol3)) k = 0;
      else if (en1_n) k = 1;
      else if (we_n) k = 2;
      else k = 3;
      ca = addr;
    end else begin
      k = lk;
      ca = {ca[5:2], ca[1:0] + 2'd1};
    end
    if (k == 3 && be_n != 2'b11) begin
      pq_due.push_back(cyc + 2); pq_addr.push_back(ca); pq_m.push_back(~be_n);
    end
    lk = k; pk = k; prd_a = ca;
  endtask

  task automatic step(input logic ld, input logic e1, input logic e2, input logic e3,
                      input logic w, input logic [1:0] b, input logic [5:0] a,
                      input logic [17:0] d);
    load_n = ld; en1_n = e1; en2 = e2; en3 = e3; we_n = w; be_n = b; addr = a; din = d;
    @(posedge clk); #1;
    model_edge();
  endtask

  task automatic wr(input logic [5:0] a, input logic [1:0] b, input logic [17:0] d);
    step(1'b0, 1'b0, pol2, pol3, 1'b0, b, a, d);
  endtask
  task automatic rd(input logic [5:0] a, input logic [17:0] d);
    step(1'b0, 1'b0, pol2, pol3, 1'b1, 2'b11, a, d);
  endtask
  task automatic ct(input logic w, input logic [1:0] b, input logic [17:0] d);
    step(1'b1, 1'b1, ~pol2, ~pol3, w, b, 6'h3f, d);
  endtask
  task automatic ds(input logic [17:0] d);
    step(1'b0, 1'b1, pol2, pol3, 1'b0, 2'b00, 6'h00, d);
  endtask
  task automatic bk(input logic [17:0] d);
    step(1'b0, 1'b0, ~pol2, pol3, 1'b0, 2'b00, 6'h00, d);
  endtask

  function automatic logic [17:0] pat(input int a);
    return 18'(a * 18'h0ab5 + 18'h1c3);
  endfunction

  initial begin
    #800000;
    nbad++; ncmp++;
    $display("FAIL R9 watchdog expired at cycle %0d: got hang expected finish", cyc);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nbad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    req_tag = "R9";
    check("reset dout_oe", {17'b0, dout_oe}, 18'd0);
    check("reset echo_en", {17'b0, echo_en}, 18'd0);
    rst = 1'b0;

    req_tag = "R1";
    for (int a = 0; a < 64; a++) wr(6'(a), 2'b00, pat(a - 2));
    ds(pat(62)); ds(pat(63));

    req_tag = "R2";
    rd(6'd5, 0); rd(6'd9, 0); rd(6'd63, 0); ds(0); ds(0);

    req_tag = "R3";
    wr(6'd12, 2'b00, 18'h3ffff); ds(18'h00000); ds(18'h2aaaa); ds(18'h15555); rd(6'd12, 0); ds(0); ds(0);

    req_tag = "R5";
    wr(6'd10, 2'b10, 0); ds(0); ds(18'h3ffff);
    wr(6'd11, 2'b11, 0); ds(0); ds(18'h12345);
    wr(6'd13, 2'b01, 0); ds(0); ds(18'h3ffff);
    rd(6'd10, 0); rd(6'd11, 0); rd(6'd13, 0); ds(0); ds(0);

    req_tag = "R4";
    pol2 = 1'b1; pol3 = 1'b0;
    rd(6'd20, 0);
    step(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 2'b11, 6'd21, 0);
    step(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 2'b11, 6'd22, 0);
    step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 6'd23, 0);
    ds(18'h3ffff); ds(18'h3ffff); rd(6'd23, 0); ds(0); ds(0);
    pol2 = 1'b0; pol3 = 1'b1;
    rd(6'd24, 0); ds(0); ds(0);

    req_tag = "R6";
    rd(6'd22, 0); ct(1'b0, 2'b00, 0); ct(1'b0, 2'b00, 0); ds(0); ds(0);

    req_tag = "R7";
    rd(6'd46, 0); ct(1'b0, 2'b00, 0); ct(1'b0, 2'b00, 0); ct(1'b0, 2'b00, 0); ct(1'b0, 2'b00, 0); ds(0); ds(0);
    wr(6'd41, 2'b00, 0); ct(1'b1, 2'b00, 0); ct(1'b1, 2'b10, 18'h11111);
    ct(1'b1, 2'b11, 18'h22222); ct(1'b1, 2'b01, 18'h03333);
    ds(18'h04444); ds(18'h05555); ds(18'h06666);
    rd(6'd40, 0); ct(1'b0, 2'b00, 0); ct(1'b0, 2'b00, 0); ct(1'b0, 2'b00, 0); ds(0); ds(0);

    req_tag = "R8";
    rd(6'd2, 0); ds(0); ct(1'b1, 2'b11, 0); ct(1'b0, 2'b00, 0); rd(6'd3, 0); wr(6'd50, 2'b00, 0);
    ds(0); ds(18'h0abcd); ds(0);

    req_tag = "R9";
    rd(6'd4, 0); bk(0); ct(1'b1, 2'b11, 0); ct(1'b0, 2'b00, 0); rd(6'd50, 0); ds(0); ds(0);

    req_tag = "R10";
    wr(6'd30, 2'b00, 0); rd(6'd30, 0); rd(6'd30, 18'h2f0f0); ds(0); ds(0);
    wr(6'd31, 2'b01, 0); rd(6'd31, 0); rd(6'd31, 18'h3ffff); ds(0); ds(0);
    wr(6'd32, 2'b00, 0); ds(0); rd(6'd32, 18'h1e1e1); ds(0); ds(0);

    req_tag = "R1";
    for (int i = 0; i < 3000; i++) begin
      logic [3:0] r;
      r = 4'($urandom);
      if (i % 500 == 0) begin pol2 = 1'($urandom); pol3 = 1'($urandom); end
      step((r < 4) ? 1'b1 : 1'b0,
           (r == 4) ? 1'b1 : 1'b0,
           (r == 5) ? ~pol2 : pol2,
           (r == 6) ? ~pol3 : pol3,
           1'($urandom), 2'($urandom), 6'($urandom % 16), 18'($urandom));
    end
    ds(0); ds(0); ds(0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nbad);
    $finish;
  end
endmodule